// File: doc/BRIEF.md
# Vector Address Offset Generator

This block produces a vector of per-lane byte offsets that a vector load/store unit adds to a scalar base to form gather or scatter addresses. It has five ways of walking an address space: linear upward, linear downward, upward around a circular buffer, downward around a circular buffer, and bit-reversed order for reordering FFT data. It holds no addressing state of its own between calls. The caller passes a start offset in and gets back the offset the next call should start from, so a loop continues the sequence by feeding that value back in.

A request is accepted with `start` while the block is idle. The request's fields are captured in that cycle, and later changes on the inputs have no effect. A controller (states IDLE, RUN, DONE) then builds the vector one lane per clock cycle in RUN and shows the finished result for one cycle in DONE. The transitions are: IDLE to RUN on a valid request, IDLE to DONE on an invalid request, RUN to DONE after the last lane, and DONE to IDLE always. The number of lanes follows the element size: 16, 8 or 4 lanes for 8-, 16- or 32-bit elements.

Top module: `vec_ofs_gen`

## Requirements
- R1: After reset, `busy`, `done` and `err` are 0, and `ofs_vec` and `next_ofs` are all zeros.
- R2: The lane count comes from `esize`: 0 gives 16 lanes, 1 gives 8 lanes and 2 gives 4 lanes. Lane k occupies `ofs_vec[16k+15:16k]`. Lanes at or above the lane count read as zero. An `esize` of 3 is invalid.
- R3: `step_sel` values 0, 1, 2 and 3 select a step of 1, 2, 4 and 8. `mode` 0 (linear up) gives lane k = (start + k*step) mod 2^16.
- R4: `mode` 1 (linear down) gives lane k = (start - k*step) mod 2^16.
- R5: `mode` 2 (circular up) gives lane k = (start + k*step) mod `buf_len`, so the offsets restart at zero after the top of the buffer.
- R6: `mode` 3 (circular down) gives lane k = (start - k*step) mod `buf_len`, taken as non-negative, so the offsets go from zero back to the top of the buffer.
- R7: `mode` 4 (bit-reverse) with n = `rev_bits` gives lane k = reverse_n((start + k) mod 2^n) * step, where reverse_n mirrors the low n bits.
- R8: On a valid request, `next_ofs` is the value that lane L would hold for L = lane count in modes 0 to 3. In mode 4 it is (start + L) mod 2^n.
- R9: A request is invalid when `mode` is 5 to 7, when `esize` is 3, when a circular mode has `buf_len` = 0, `buf_len` not a multiple of the step, or start >= `buf_len`, or when bit-reverse mode has `rev_bits` = 0 or `rev_bits` > 8. An invalid request gives `err` = 1, an all-zero `ofs_vec` and `next_ofs` = start.
- R10: A valid request raises `busy` in the cycle after the accepting edge. `done` is high for exactly one cycle, L clock edges after the accepting edge. For an invalid request `done` is high in the cycle right after the accepting edge and `busy` never rises.
- R11: `start` is ignored while `busy` or `done` is high. Input changes after the accepting edge do not alter the result.
- R12: `ofs_vec`, `next_ofs` and `err` hold their values from `done` until the next request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request strobe, taken when idle |
| mode | input | 3 | Walk mode, 0 to 4 |
| esize | input | 2 | Element size code, selects lane count |
| step_sel | input | 2 | Step code, step = 1 << step_sel |
| start_ofs | input | 16 | Start offset of this call |
| buf_len | input | 16 | Circular buffer length for modes 2 and 3 |
| rev_bits | input | 4 | Bit count for mode 4 |
| busy | output | 1 | Lanes are being generated |
| done | output | 1 | One-cycle result strobe |
| err | output | 1 | Last request was invalid |
| ofs_vec | output | 256 | Offset vector, 16 lanes of 16 bits |
| next_ofs | output | 16 | Start offset for the next call |

## Verification
The bench builds the block with its default parameters: 16-bit offsets, 16 lanes and a bit-reverse width of up to 8. With these values every lane count (4, 8 and 16) is reachable, along with all four steps, buffer lengths up to a few hundred bytes and every bit-reverse width from 1 to 8. The 16-bit offset width puts the wrap of the linear modes through 2^16 within reach of directed starts near 0xFFFF and near 0. The random requests mix invalid requests with valid ones. On about a third of the valid requests the inputs are scrambled and `start` is held during the run, to show that the captured request alone decides the result.

// File: rtl/vog_pkg.sv
package vog_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } vog_state_e;

    localparam logic [2:0] MD_UP    = 3'd0;
    localparam logic [2:0] MD_DOWN  = 3'd1;
    localparam logic [2:0] MD_UPW   = 3'd2;
    localparam logic [2:0] MD_DOWNW = 3'd3;
    localparam logic [2:0] MD_BREV  = 3'd4;
endpackage

// File: rtl/vog_cfg_chk.sv
module vog_cfg_chk
    import vog_pkg::*;
#(
    parameter int OFS_W     = 16,
    parameter int MAX_LANES = 16,
    parameter int RB_MAX    = 8,
    parameter int RB_W      = 4,
    parameter int LANE_W    = 5
) (
    input  logic [2:0]        mode,
    input  logic [1:0]        esize,
    input  logic [1:0]        step_sel,
    input  logic [OFS_W-1:0]  start_ofs,
    input  logic [OFS_W-1:0]  buf_len,
    input  logic [RB_W-1:0]   rev_bits,
    output logic              bad,
    output logic [LANE_W-1:0] lanes
);
    logic [OFS_W-1:0] step_m1;
    logic             len_bad;
    logic             rev_bad;
    logic             mode_bad;

    always_comb begin
        step_m1  = (OFS_W'(1) << step_sel) - OFS_W'(1);
        len_bad  = (buf_len == '0) || ((buf_len & step_m1) != '0) || (start_ofs >= buf_len);
        rev_bad  = (rev_bits == '0) || (int'(rev_bits) > RB_MAX);
        mode_bad = (mode > MD_BREV);
        lanes    = (esize == 2'd3) ? '0 : LANE_W'(MAX_LANES >> esize);
        bad      = mode_bad || (esize == 2'd3)
                 || (((mode == MD_UPW) || (mode == MD_DOWNW)) && len_bad)
                 || ((mode == MD_BREV) && rev_bad);
    end
endmodule

// File: rtl/vog_lane_alu.sv
module vog_lane_alu
    import vog_pkg::*;
#(
    parameter int OFS_W  = 16,
    parameter int RB_MAX = 8,
    parameter int RB_W   = 4
) (
    input  logic [2:0]       mode,
    input  logic [1:0]       step_sel,
    input  logic [OFS_W-1:0] buf_len,
    input  logic [RB_W-1:0]  nbits,
    input  logic [OFS_W-1:0] cur,
    output logic [OFS_W-1:0] lane_val,
    output logic [OFS_W-1:0] adv_val
);
    logic [OFS_W-1:0]  step;
    logic [OFS_W-1:0]  mask;
    logic [OFS_W:0]    sum_up;
    logic [RB_MAX-1:0] rev_full;
    logic [RB_MAX-1:0] rev_n;

    always_comb begin
        step   = OFS_W'(1) << step_sel;
        mask   = OFS_W'((32'd1 << nbits) - 32'd1);
        sum_up = {1'b0, cur} + {1'b0, step};
        for (int b = 0; b < RB_MAX; b++) begin
            rev_full[RB_MAX-1-b] = cur[b];
        end
        rev_n = rev_full >> (RB_MAX - int'(nbits));

        lane_val = cur;
        adv_val  = cur;
        unique case (mode)
            MD_UP:    adv_val = sum_up[OFS_W-1:0];
            MD_DOWN:  adv_val = cur - step;
            MD_UPW: begin
                if (sum_up >= {1'b0, buf_len}) adv_val = OFS_W'(sum_up - {1'b0, buf_len});
                else                           adv_val = sum_up[OFS_W-1:0];
            end
            MD_DOWNW: begin
                if (cur < step) adv_val = cur + buf_len - step;
                else            adv_val = cur - step;
            end
            MD_BREV: begin
                lane_val = OFS_W'(rev_n) << step_sel;
                adv_val  = (cur + OFS_W'(1)) & mask;
            end
            default: begin
                lane_val = cur;
                adv_val  = cur;
            end
        endcase
    end
endmodule

// File: rtl/vec_ofs_gen.sv
module vec_ofs_gen
    import vog_pkg::*;
#(
    parameter int OFS_W     = 16,
    parameter int MAX_LANES = 16,
    parameter int RB_MAX    = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       start,
    input  logic [2:0]                 mode,
    input  logic [1:0]                 esize,
    input  logic [1:0]                 step_sel,
    input  logic [15:0]                start_ofs,
    input  logic [15:0]                buf_len,
    input  logic [3:0]                 rev_bits,
    output logic                       busy,
    output logic                       done,
    output logic                       err,
    output logic [255:0]               ofs_vec,
    output logic [15:0]                next_ofs
);
    localparam int RB_W   = $clog2(RB_MAX + 1);
    localparam int LANE_W = $clog2(MAX_LANES + 1);
    localparam int VEC_W  = OFS_W * MAX_LANES;

    vog_state_e          state_q, state_d;
    logic [2:0]          mode_q;
    logic [1:0]          step_sel_q;
    logic [OFS_W-1:0]    len_q;
    logic [RB_W-1:0]     nbits_q;
    logic [OFS_W-1:0]    cur_q;
    logic [LANE_W-1:0]   idx_q;
    logic [LANE_W-1:0]   lanes_q;
    logic                err_q;
    logic [VEC_W-1:0]    vec_q;
    logic [OFS_W-1:0]    next_q;

    logic                req_bad;
    logic [LANE_W-1:0]   req_lanes;
    logic [OFS_W-1:0]    lane_val;
    logic [OFS_W-1:0]    adv_val;
    logic                last_lane;

    vog_cfg_chk #(
        .OFS_W(OFS_W), .MAX_LANES(MAX_LANES), .RB_MAX(RB_MAX),
        .RB_W(RB_W), .LANE_W(LANE_W)
    ) u_cfg (
        .mode(mode), .esize(esize), .step_sel(step_sel),
        .start_ofs(OFS_W'(start_ofs)), .buf_len(OFS_W'(buf_len)),
        .rev_bits(RB_W'(rev_bits)),
        .bad(req_bad), .lanes(req_lanes)
    );

    vog_lane_alu #(
        .OFS_W(OFS_W), .RB_MAX(RB_MAX), .RB_W(RB_W)
    ) u_alu (
        .mode(mode_q), .step_sel(step_sel_q), .buf_len(len_q),
        .nbits(nbits_q), .cur(cur_q),
        .lane_val(lane_val), .adv_val(adv_val)
    );

    assign last_lane = (LANE_W'(idx_q + 1'b1) == lanes_q);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start) state_d = req_bad ? ST_DONE : ST_RUN;
            ST_RUN:  if (last_lane) state_d = ST_DONE;
            ST_DONE: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q     <= '0;
            step_sel_q <= '0;
            len_q      <= '0;
            nbits_q    <= '0;
            cur_q      <= '0;
            idx_q      <= '0;
            lanes_q    <= '0;
            err_q      <= 1'b0;
            vec_q      <= '0;
            next_q     <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        mode_q     <= mode;
                        step_sel_q <= step_sel;
                        len_q      <= OFS_W'(buf_len);
                        nbits_q    <= RB_W'(rev_bits);
                        cur_q      <= OFS_W'(start_ofs);
                        idx_q      <= '0;
                        lanes_q    <= req_lanes;
                        vec_q      <= '0;
                        err_q      <= req_bad;
                        next_q     <= OFS_W'(start_ofs);
                    end
                end
                ST_RUN: begin
                    vec_q[int'(idx_q)*OFS_W +: OFS_W] <= lane_val;
                    cur_q <= adv_val;
                    idx_q <= idx_q + 1'b1;
                    if (last_lane) next_q <= adv_val;
                end
                default: ;
            endcase
        end
    end

    assign busy     = (state_q == ST_RUN);
    assign done     = (state_q == ST_DONE);
    assign err      = err_q;
    assign ofs_vec  = 256'(vec_q);
    assign next_ofs = 16'(next_q);

    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R10
    accept_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && start) |=> (busy || done));

    // R11
    cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> ($stable(mode_q) && $stable(len_q) && $stable(lanes_q)));

    // R5
    upw_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && mode_q == MD_UPW) |-> (lane_val < len_q && adv_val < len_q));

    // R6
    downw_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && mode_q == MD_DOWNW) |-> (lane_val < len_q && adv_val < len_q));

    // R7
    brev_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && mode_q == MD_BREV) |-> (((lane_val >> step_sel_q) >> nbits_q) == '0));

    // R9
    err_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && err) |-> (ofs_vec == '0));

    // R12
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && !start && $past(state_q == ST_DONE || state_q == ST_IDLE))
            |=> ($stable(ofs_vec) && $stable(next_ofs) && $stable(err)));
endmodule

// File: tb/tb_vec_ofs_gen.sv
module tb_vec_ofs_gen;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [2:0]   mode = '0;
    logic [1:0]   esize = '0;
    logic [1:0]   step_sel = '0;
    logic [15:0]  start_ofs = '0;
    logic [15:0]  buf_len = '0;
    logic [3:0]   rev_bits = '0;
    logic         busy, done, err;
    logic [255:0] ofs_vec;
    logic [15:0]  next_ofs;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    vec_ofs_gen dut (
        .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .esize(esize),
        .step_sel(step_sel), .start_ofs(start_ofs), .buf_len(buf_len),
        .rev_bits(rev_bits), .busy(busy), .done(done), .err(err),
        .ofs_vec(ofs_vec), .next_ofs(next_ofs)
    );

    function automatic int lane_count(int e);
        if (e == 0) return 16;
        if (e == 1) return 8;
        if (e == 2) return 4;
        return 0;
    endfunction

    function automatic bit is_bad(int m, int e, int ss, int st, int ln, int nb);
        int stp = 1 << ss;
        if (m > 4 || e == 3) return 1'b1;
        if ((m == 2 || m == 3) && (ln == 0 || (ln % stp) != 0 || st >= ln)) return 1'b1;
        if (m == 4 && (nb == 0 || nb > 8)) return 1'b1;
        return 1'b0;
    endfunction

    function automatic int exp_lane(int m, int ss, int st, int ln, int nb, int k);
        int stp = 1 << ss;
        int r;
        int idx;
        case (m)
            0: return (st + k * stp) & 16'hFFFF;
            1: return (st - k * stp) & 16'hFFFF;
            2: return (st + k * stp) % ln;
            3: begin
                r = (st - k * stp) % ln;
                if (r < 0) r = r + ln;
                return r;
            end
            default: begin
                idx = (st + k) % (1 << nb);
                r = 0;
                for (int b = 0; b < nb; b++)
                    if (((idx >> b) & 1) != 0) r = r | (1 << (nb - 1 - b));
                return r * stp;
            end
        endcase
    endfunction

    function automatic int exp_next(int m, int ss, int st, int ln, int nb, int lanes);
        if (m == 4) return (st + lanes) % (1 << nb);
        return exp_lane(m, ss, st, ln, nb, lanes);
    endfunction

    task automatic check(bit ok, string req, string what, int act, int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
        end
    endtask

    task automatic run_op(int m, int e, int ss, int st, int ln, int nb, bit scramble, string req);
        bit bad = is_bad(m, e, ss, st, ln, nb);
        int lanes = bad ? 0 : lane_count(e);
        int cnt = 0;
        int elat = bad ? 0 : lanes;
        bit vec_ok = 1'b1;
        int bad_lane = 0;
        int act_l = 0;
        int exp_l = 0;
        int ev;
        @(negedge clk);
        mode = 3'(m); esize = 2'(e); step_sel = 2'(ss);
        start_ofs = 16'(st); buf_len = 16'(ln); rev_bits = 4'(nb);
        start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        if (scramble && !bad) begin
            mode = 3'($urandom); esize = 2'($urandom); step_sel = 2'($urandom);
            start_ofs = 16'($urandom); buf_len = 16'($urandom); rev_bits = 4'($urandom);
        end else begin
            start = 1'b0;
        end
        if (!bad) check(busy === 1'b1, "R10", "busy after accept", int'(busy), 1);
        while (done !== 1'b1 && cnt < 40) begin
            @(posedge clk);
            @(negedge clk);
            cnt++;
            if (cnt == 2) start = 1'b0;
        end
        start = 1'b0;
        check(cnt == elat, "R10", "done latency", cnt, elat);
        check(err === bad, "R9", "err flag", int'(err), int'(bad));
        for (int k = 0; k < 16; k++) begin
            ev = (k < lanes) ? exp_lane(m, ss, st, ln, nb, k) : 0;
            if (int'(ofs_vec[k*16 +: 16]) != ev && vec_ok) begin
                vec_ok = 1'b0; bad_lane = k; act_l = int'(ofs_vec[k*16 +: 16]); exp_l = ev;
            end
        end
        check(vec_ok, req, $sformatf("ofs_vec lane %0d", bad_lane), act_l, exp_l);
        ev = bad ? st : exp_next(m, ss, st, ln, nb, lanes);
        check(int'(next_ofs) == ev, bad ? "R9" : "R8", "next_ofs", int'(next_ofs), ev);
        @(posedge clk);
        @(negedge clk);
        check(done === 1'b0, "R10", "done one cycle", int'(done), 0);
        @(posedge clk);
        @(negedge clk);
        check(int'(next_ofs) == ev, "R12", "next_ofs held", int'(next_ofs), ev);
    endtask

    initial begin : watchdog
        for (int c = 0; c < 150000; c++) begin
            @(posedge clk);
            if (finished) disable watchdog;
        end
        fails++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        int m, e, ss, st, ln, nb, stp;
        bit scr;
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(busy === 1'b0 && done === 1'b0 && err === 1'b0, "R1", "flags in reset",
              int'({busy, done, err}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(ofs_vec === '0 && next_ofs === '0, "R1", "outputs after reset", int'(next_ofs), 0);

        // directed corners
        run_op(2, 2, 1, 6, 8, 0, 1'b0, "R5");       // 6,0,2,4 next 6
        run_op(3, 2, 1, 0, 8, 0, 1'b0, "R6");       // 0,6,4,2 next 0
        run_op(4, 1, 0, 0, 0, 3, 1'b0, "R7");       // 0,4,2,6,1,5,3,7
        run_op(4, 2, 3, 5, 0, 8, 1'b0, "R7");
        run_op(0, 2, 0, 16'hFFFE, 0, 0, 1'b0, "R3"); // wraps through 2^16
        run_op(1, 2, 1, 1, 0, 0, 1'b0, "R4");
        run_op(0, 0, 3, 100, 0, 0, 1'b0, "R2");
        run_op(1, 1, 2, 40, 0, 0, 1'b1, "R11");
        run_op(2, 0, 2, 12, 24, 0, 1'b1, "R11");
        run_op(2, 2, 0, 0, 0, 0, 1'b0, "R9");       // zero length
        run_op(3, 2, 2, 0, 6, 0, 1'b0, "R9");       // length not multiple of step
        run_op(2, 2, 0, 8, 8, 0, 1'b0, "R9");       // start at buffer end
        run_op(4, 2, 0, 0, 0, 9, 1'b0, "R9");       // too many reverse bits
        run_op(0, 3, 0, 0, 0, 0, 1'b0, "R2");       // esize 3 invalid
        run_op(6, 0, 0, 7, 0, 0, 1'b0, "R9");       // mode out of range

        for (int i = 0; i < 120; i++) begin
            m  = ($urandom % 10 == 0) ? 5 + int'($urandom % 3) : int'($urandom % 5);
            e  = ($urandom % 8 == 0) ? 3 : int'($urandom % 3);
            ss = int'($urandom % 4);
            stp = 1 << ss;
            ln = ($urandom % 10 == 0) ? int'($urandom % 64) : stp * (1 + int'($urandom % 40));
            nb = ($urandom % 10 == 0) ? int'($urandom % 16) : 1 + int'($urandom % 8);
            if ((m == 2 || m == 3) && ln > 0 && ($urandom % 10 != 0)) st = int'($urandom % ln);
            else st = int'($urandom % 65536);
            scr = ($urandom % 3 == 0);
            run_op(m, e, ss, st, ln, nb, scr,
                   (m == 0) ? "R3" : (m == 1) ? "R4" : (m == 2) ? "R5" :
                   (m == 3) ? "R6" : (m == 4) ? "R7" : "R9");
        end

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule